// File: doc/BRIEF.md
# Multi-Width Integer ALU with Status Flags

This block is the arithmetic part of an integer execution unit. It takes two operands, an incoming carry and an opcode. It produces the result and six status flags for 8-bit, 16-bit or 32-bit work, chosen per request by a size field. The operations are:

- add, subtract, add-with-carry and subtract-with-borrow;
- increment and decrement;
- two's-complement negate.

Each result carries a write-enable mask. The mask tells a flags register, which sits outside this block, which of the six flags the operation updates. A chain of add-with-carry or subtract-with-borrow requests, each fed the carry of the one before, builds arithmetic wider than 32 bits.

Requests enter on a valid/ready stream and leave on a valid/ready stream. A single output register sits between them.

- `in_ready` is high whenever the output register is empty, or when its contents leave in the same cycle.
- A request is taken on a rising edge where `in_valid` and `in_ready` are both high.
- Its result appears on the next cycle with `out_valid` high.
- While `out_ready` is low, the result stays on the outputs unchanged, and any waiting request is held off.
- The opcode, size and operand pins act only at the handshake.

Top module: `multiwidth_alu`

## Requirements
- R1: Size code 2'b00 selects 8 bits, 2'b01 selects 16 bits, and 2'b10 or 2'b11 selects 32 bits. Operand bits above the selected width have no effect on any output, and `result` bits above the selected width are zero.
- R2: Opcodes are 0 add, 1 subtract, 2 add-with-carry, 3 subtract-with-borrow, 4 increment, 5 decrement, 6 negate and 7 reserved. Add gives a+b, and add-with-carry gives a+b+carry_in, both truncated to the selected width. Carry (flag bit 0) is the carry out of the top bit of the selected width.
- R3: Subtract gives a-b, and subtract-with-borrow gives a-b-carry_in. For both, carry is set exactly when the subtrahend, together with any borrow-in, exceeds a as an unsigned value (a borrow).
- R4: Overflow (flag bit 5) is set exactly when the exact signed result of the operation lies outside the signed range of the selected width.
- R5: Sign (flag bit 4) equals the top bit of the result at the selected width. Zero (flag bit 3) is set exactly when the result at that width is all zeros.
- R6: Auxiliary carry (flag bit 2) is set on a carry out of bit 3 into bit 4 for adding operations, and on a borrow into bit 3 for subtracting operations, decrement and negate.
- R7: Parity (flag bit 1) is set when bits 7..0 of the result hold an even number of ones, at every width.
- R8: Increment and decrement give a+1 and a-1. Their write mask is 6'b111110: carry is not written and the other five flags are.
- R9: Negate gives 0-a and writes all six flags. Its carry is set exactly when the operand at the selected width is nonzero.
- R10: Opcode 7 gives a zero result and a zero write mask.
- R11: `in_ready` equals (not `out_valid`) or `out_ready`. Each accepted request yields exactly one result, in order. While `out_valid` is high and `out_ready` is low, `result`, `flags` and `flags_we` hold steady.
- R12: While `rst_n` is low and after it is released, `out_valid` is low until the first accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| op | input | 3 | Operation code (see R2) |
| size | input | 2 | Operand width code (see R1) |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand (add/sub forms only) |
| carry_in | input | 1 | Carry from the flags register |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| result | output | 32 | Result, zero above the selected width |
| flags | output | 6 | {overflow, sign, zero, aux, parity, carry} |
| flags_we | output | 6 | Per-flag write enable, same bit order |

## Verification
The bench builds the block with its default parameters: a 32-bit maximum width, an 8-bit base lane and three lane sizes. With these values every width code is reachable, including the 2'b11 alias of 32 bits. So is the truncation of wide operand bits at 8 and 16 bits. At 8 bits, the signed and unsigned boundaries such as 7Fh+1, 80h negated and 0 minus borrow can be driven directly. The consumer side stalls in a repeating pattern, so back-pressure and the holding of results are exercised alongside the arithmetic.

// File: rtl/mwalu_pkg.sv
`timescale 1ns/1ps
package mwalu_pkg;

  localparam int FLAG_N = 6;
  localparam int FLG_C  = 0;
  localparam int FLG_P  = 1;
  localparam int FLG_A  = 2;
  localparam int FLG_Z  = 3;
  localparam int FLG_S  = 4;
  localparam int FLG_O  = 5;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_ADC  = 3'd2,
    OP_SBB  = 3'd3,
    OP_INC  = 3'd4,
    OP_DEC  = 3'd5,
    OP_NEG  = 3'd6,
    OP_NONE = 3'd7
  } alu_op_e;

  // Bit order of this struct matches the flags / flags_we ports.
  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zer;
    logic aux;
    logic par;
    logic cry;
  } flags_t;

  localparam flags_t WE_ALL    = '{ovf: 1'b1, sgn: 1'b1, zer: 1'b1, aux: 1'b1, par: 1'b1, cry: 1'b1};
  localparam flags_t WE_NO_CRY = '{ovf: 1'b1, sgn: 1'b1, zer: 1'b1, aux: 1'b1, par: 1'b1, cry: 1'b0};
  localparam flags_t WE_NONE   = '0;

endpackage

// File: rtl/mwalu_operand_prep.sv
`timescale 1ns/1ps
// Maps every operation onto one adder form x + y + c.
// "inv" marks the subtracting forms, whose carry and aux flags are borrows.
module mwalu_operand_prep
  import mwalu_pkg::*;
#(
  parameter int MAX_W = 32
) (
  input  logic [2:0]       op,
  input  logic [MAX_W-1:0] a,
  input  logic [MAX_W-1:0] b,
  input  logic             cin,
  output logic [MAX_W-1:0] x,
  output logic [MAX_W-1:0] y,
  output logic             c,
  output logic             inv,
  output logic             kill,
  output flags_t           we
);

  always_comb begin
    x    = a;
    y    = b;
    c    = 1'b0;
    inv  = 1'b0;
    kill = 1'b0;
    we   = WE_ALL;
    unique case (alu_op_e'(op))
      OP_ADD: ;
      OP_ADC: c = cin;
      OP_SUB: begin
        y   = ~b;
        c   = 1'b1;
        inv = 1'b1;
      end
      OP_SBB: begin
        y   = ~b;
        c   = ~cin;
        inv = 1'b1;
      end
      OP_INC: begin
        y  = '0;
        c  = 1'b1;
        we = WE_NO_CRY;
      end
      OP_DEC: begin
        y   = '1;
        inv = 1'b1;
        we  = WE_NO_CRY;
      end
      OP_NEG: begin
        x   = '0;
        y   = ~a;
        c   = 1'b1;
        inv = 1'b1;
      end
      default: begin
        x    = '0;
        y    = '0;
        kill = 1'b1;
        we   = WE_NONE;
      end
    endcase
  end

endmodule

// File: rtl/mwalu_lanes.sv
`timescale 1ns/1ps
// One adder per supported width. The selected lane provides the sum and
// the carries around its top bit.
module mwalu_lanes #(
  parameter int MAX_W   = 32,
  parameter int BASE_W  = 8,
  parameter int N_SIZES = 3,
  parameter int SEL_W   = 2
) (
  input  logic [MAX_W-1:0] x,
  input  logic [MAX_W-1:0] y,
  input  logic             c,
  input  logic [SEL_W-1:0] sel,
  output logic [MAX_W-1:0] sum,
  output logic             cout,
  output logic             cmsb,
  output logic             msb,
  output logic             nib_c
);

  logic [MAX_W-1:0] lane_sum [N_SIZES];
  logic             lane_co  [N_SIZES];
  logic             lane_ci  [N_SIZES];
  logic             lane_top [N_SIZES];

  for (genvar g = 0; g < N_SIZES; g++) begin : g_lane
    localparam int W = BASE_W << g;
    logic [W:0] s;
    assign s = {1'b0, x[W-1:0]} + {1'b0, y[W-1:0]} + {{W{1'b0}}, c};
    if (W < MAX_W) begin : g_pad
      assign lane_sum[g] = {{(MAX_W-W){1'b0}}, s[W-1:0]};
    end else begin : g_full
      assign lane_sum[g] = s[W-1:0];
    end
    assign lane_co[g]  = s[W];
    assign lane_ci[g]  = s[W-1] ^ x[W-1] ^ y[W-1];
    assign lane_top[g] = s[W-1];
  end

  // The carry out of the low nibble is the same for every width.
  logic [4:0] nib;
  assign nib   = {1'b0, x[3:0]} + {1'b0, y[3:0]} + {4'b0, c};
  assign nib_c = nib[4];

  always_comb begin
    sum  = '0;
    cout = 1'b0;
    cmsb = 1'b0;
    msb  = 1'b0;
    for (int i = 0; i < N_SIZES; i++) begin
      if (sel == SEL_W'(i)) begin
        sum  = lane_sum[i];
        cout = lane_co[i];
        cmsb = lane_ci[i];
        msb  = lane_top[i];
      end
    end
  end

endmodule

// File: rtl/mwalu_flag_gen.sv
`timescale 1ns/1ps
module mwalu_flag_gen
  import mwalu_pkg::*;
#(
  parameter int MAX_W = 32
) (
  input  logic [MAX_W-1:0] sum,
  input  logic             cout,
  input  logic             cmsb,
  input  logic             msb,
  input  logic             nib_c,
  input  logic             inv,
  input  logic             kill,
  output logic [MAX_W-1:0] res,
  output flags_t           flg
);

  always_comb begin
    res = kill ? '0 : sum;
    flg = '0;
    if (!kill) begin
      flg.cry = cout ^ inv;
      flg.ovf = cout ^ cmsb;
      flg.sgn = msb;
      flg.zer = (sum == '0);
      flg.aux = nib_c ^ inv;
      flg.par = ~^sum[7:0];
    end
  end

endmodule

// File: rtl/mwalu_out_reg.sv
`timescale 1ns/1ps
// Single valid/ready register stage.
module mwalu_out_reg #(
  parameter int DW = 44
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data
);

  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
    end else if (s_ready) begin
      m_valid <= s_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (s_valid && s_ready) begin
      m_data <= s_data;
    end
  end

endmodule

// File: rtl/multiwidth_alu.sv
`timescale 1ns/1ps
module multiwidth_alu
  import mwalu_pkg::*;
#(
  parameter int MAX_W   = 32,
  parameter int BASE_W  = 8,
  parameter int N_SIZES = 3,
  parameter int SIZE_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        op,
  input  logic [SIZE_W-1:0] size,
  input  logic [MAX_W-1:0]  opa,
  input  logic [MAX_W-1:0]  opb,
  input  logic              carry_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [MAX_W-1:0]  result,
  output logic [FLAG_N-1:0] flags,
  output logic [FLAG_N-1:0] flags_we
);

  localparam int PAY_W   = MAX_W + 2 * FLAG_N;
  localparam int TOP_SEL = N_SIZES - 1;

  // Width codes above the largest lane alias to the largest lane.
  logic [SIZE_W-1:0] sel;
  assign sel = (size > SIZE_W'(TOP_SEL)) ? SIZE_W'(TOP_SEL) : size;

  logic [MAX_W-1:0] x, y;
  logic             c, inv, kill;
  flags_t           we;

  mwalu_operand_prep #(.MAX_W(MAX_W)) u_prep (
    .op   (op),
    .a    (opa),
    .b    (opb),
    .cin  (carry_in),
    .x    (x),
    .y    (y),
    .c    (c),
    .inv  (inv),
    .kill (kill),
    .we   (we)
  );

  logic [MAX_W-1:0] sum;
  logic             cout, cmsb, msb, nib_c;

  mwalu_lanes #(
    .MAX_W   (MAX_W),
    .BASE_W  (BASE_W),
    .N_SIZES (N_SIZES),
    .SEL_W   (SIZE_W)
  ) u_lanes (
    .x     (x),
    .y     (y),
    .c     (c),
    .sel   (sel),
    .sum   (sum),
    .cout  (cout),
    .cmsb  (cmsb),
    .msb   (msb),
    .nib_c (nib_c)
  );

  logic [MAX_W-1:0] res;
  flags_t           flg;

  mwalu_flag_gen #(.MAX_W(MAX_W)) u_flags (
    .sum   (sum),
    .cout  (cout),
    .cmsb  (cmsb),
    .msb   (msb),
    .nib_c (nib_c),
    .inv   (inv),
    .kill  (kill),
    .res   (res),
    .flg   (flg)
  );

  logic [PAY_W-1:0] pay_q;

  mwalu_out_reg #(.DW(PAY_W)) u_oreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  ({res, flg, we}),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (pay_q)
  );

  assign result   = pay_q[PAY_W-1 -: MAX_W];
  assign flags    = pay_q[2*FLAG_N-1 -: FLAG_N];
  assign flags_we = pay_q[FLAG_N-1:0];

endmodule

// File: rtl/mwalu_chk.sv
`timescale 1ns/1ps
module mwalu_chk #(
  parameter int MAX_W  = 32,
  parameter int BASE_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       op,
  input logic [1:0]       size,
  input logic [MAX_W-1:0] opa,
  input logic             out_valid,
  input logic             out_ready,
  input logic [MAX_W-1:0] result,
  input logic [5:0]       flags,
  input logic [5:0]       flags_we
);

  logic take;
  assign take = in_valid && in_ready;

  // R1
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && size == 2'b00 |=> result[MAX_W-1:BASE_W] == '0);

  // R5
  narrow_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && size == 2'b00 && op != 3'd7 |=> flags[4] == result[BASE_W-1]);

  // R5
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flags_we[3] |-> flags[3] == (result == '0));

  // R7
  parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flags_we[1] |-> flags[1] == ~^result[7:0]);

  // R8
  incdec_keep_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && (op == 3'd4 || op == 3'd5) |=> out_valid && flags_we == 6'b111110);

  // R9
  neg_nonzero_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && op == 3'd6 && size == 2'b10 && opa != '0 |=> flags[0] && flags_we[0]);

  // R10
  reserved_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && op == 3'd7 |=> flags_we == 6'b0 && result == '0);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result) && $stable(flags) && $stable(flags_we));

  // R11
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));

endmodule

bind multiwidth_alu mwalu_chk #(.MAX_W(MAX_W), .BASE_W(BASE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .op        (op),
  .size      (size),
  .opa       (opa),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .result    (result),
  .flags     (flags),
  .flags_we  (flags_we)
);

// File: tb/multiwidth_alu_test.sv
`timescale 1ns/1ps
module multiwidth_alu_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  op = '0;
  logic [1:0]  size = '0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic        carry_in = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] result;
  logic [5:0]  flags;
  logic [5:0]  flags_we;

  always #10 clk = ~clk;

  multiwidth_alu uut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
    .op (op), .size (size), .opa (opa), .opb (opb), .carry_in (carry_in),
    .out_valid (out_valid), .out_ready (out_ready), .result (result),
    .flags (flags), .flags_we (flags_we)
  );

  typedef struct {
    logic [31:0] r;
    logic [5:0]  f;
    logic [5:0]  we;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   gen_done = 1'b0;
  bit   finished = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // Reference model written from the requirements.
  function automatic exp_t model(input logic [2:0] o, input logic [1:0] sz,
                                 input logic [31:0] a, input logic [31:0] b,
                                 input logic ci, input string tag);
    exp_t   e;
    int     w;
    longint m, am, bm, as, bs, full, ex, smax, smin, r;
    logic   cf, af;
    w  = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    m  = (longint'(1) << w) - 1;
    am = longint'(a) & m;
    bm = longint'(b) & m;
    as = am[w-1] ? am - (longint'(1) << w) : am;
    bs = bm[w-1] ? bm - (longint'(1) << w) : bm;
    smax = (longint'(1) << (w - 1)) - 1;
    smin = -(longint'(1) << (w - 1));
    e.tag = tag;
    e.we  = 6'b111111;
    cf = 1'b0;
    af = 1'b0;
    full = 0;
    ex = 0;
    case (o)
      3'd0: begin full = am + bm; ex = as + bs; cf = full[w];
                  af = ((am & 15) + (bm & 15)) > 15; end
      3'd2: begin full = am + bm + ci; ex = as + bs + ci; cf = full[w];
                  af = ((am & 15) + (bm & 15) + ci) > 15; end
      3'd1: begin full = am - bm; ex = as - bs; cf = am < bm;
                  af = (am & 15) < (bm & 15); end
      3'd3: begin full = am - bm - ci; ex = as - bs - ci; cf = am < bm + ci;
                  af = (am & 15) < (bm & 15) + ci; end
      3'd4: begin full = am + 1; ex = as + 1; af = (am & 15) == 15; e.we = 6'b111110; end
      3'd5: begin full = am - 1; ex = as - 1; af = (am & 15) == 0; e.we = 6'b111110; end
      3'd6: begin full = -am; ex = -as; cf = am != 0; af = (am & 15) != 0; end
      default: begin
        e.r = '0; e.f = '0; e.we = '0;
        return e;
      end
    endcase
    r = full & m;
    e.r = r[31:0];
    e.f[0] = cf;
    e.f[1] = ~^e.r[7:0];
    e.f[2] = af;
    e.f[3] = (r == 0);
    e.f[4] = r[w-1];
    e.f[5] = (ex > smax) || (ex < smin);
    return e;
  endfunction

  task automatic drive(input logic [2:0] o, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] b, input logic ci, input string tag);
    @(negedge clk);
    op = o; size = sz; opa = a; opb = b; carry_in = ci;
    in_valid = 1'b1;
    forever begin
      #3;
      if (in_ready) break;
      @(negedge clk);
    end
    sbq.push_back(model(o, sz, a, b, ci, tag));
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // Monitor with a repeating back-pressure pattern on out_ready.
  initial begin
    int          cnt = 0;
    bit          was_stalled = 1'b0;
    logic [31:0] held_r = '0;
    logic [5:0]  held_f = '0;
    forever begin
      @(negedge clk);
      cnt++;
      out_ready = rst_n && (cnt % 5 != 3) && (cnt % 7 != 0);
      #2;
      if (was_stalled) begin
        check(out_valid && result == held_r && flags == held_f, "R11", "stall hold",
              result, held_r);
      end
      was_stalled = out_valid && !out_ready;
      held_r = result;
      held_f = flags;
      if (out_valid && out_ready) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R11", "unexpected result", result, 32'h0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          check(result == e.r, e.tag, "result", result, e.r);
          check(flags_we == e.we, e.tag, "flag write mask", {26'h0, flags_we}, {26'h0, e.we});
          check((flags & e.we) == (e.f & e.we), e.tag, "flags",
                {26'h0, flags & e.we}, {26'h0, e.f & e.we});
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R11 watchdog expired actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check(out_valid == 1'b0, "R12", "out_valid in reset", {31'h0, out_valid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check(out_valid == 1'b0, "R12", "out_valid after reset", {31'h0, out_valid}, 32'h0);
    check(in_ready == 1'b1, "R11", "in_ready when empty", {31'h0, in_ready}, 32'h1);

    drive(3'd1, 2'b00, 32'h26, 32'h95, 1'b0, "R3");        // 91h, C O S set
    drive(3'd0, 2'b00, 32'hFF, 32'h01, 1'b0, "R2");        // wraps to zero
    drive(3'd0, 2'b00, 32'h7F, 32'h01, 1'b0, "R4");        // signed overflow
    drive(3'd0, 2'b00, 32'h08, 32'h08, 1'b0, "R6");        // nibble carry
    drive(3'd1, 2'b00, 32'h10, 32'h01, 1'b0, "R6");        // nibble borrow
    drive(3'd2, 2'b00, 32'hFF, 32'h00, 1'b1, "R2");        // carry-in only
    drive(3'd0, 2'b10, 32'hFFFF_FFFF, 32'h1, 1'b0, "R2");  // low word of chain
    drive(3'd2, 2'b10, 32'h0000_0001, 32'h2, 1'b1, "R2");  // high word of chain
    drive(3'd3, 2'b00, 32'h00, 32'h00, 1'b1, "R3");        // borrow-in only
    drive(3'd3, 2'b10, 32'h8000_0000, 32'h0, 1'b1, "R4");  // signed underflow
    drive(3'd4, 2'b00, 32'hFF, 32'h0, 1'b0, "R8");
    drive(3'd4, 2'b00, 32'h7F, 32'h0, 1'b1, "R8");
    drive(3'd5, 2'b01, 32'h0000, 32'h0, 1'b0, "R8");
    drive(3'd6, 2'b00, 32'h80, 32'h0, 1'b0, "R9");
    drive(3'd6, 2'b10, 32'h0, 32'h0, 1'b0, "R9");
    drive(3'd6, 2'b01, 32'h1, 32'h0, 1'b0, "R9");
    drive(3'd0, 2'b00, 32'h1234_5678, 32'hAABB_CCDD, 1'b0, "R1");
    drive(3'd1, 2'b01, 32'hFFFF_1234, 32'h9999_1234, 1'b0, "R5");
    drive(3'd0, 2'b11, 32'h7FFF_FFFF, 32'h1, 1'b0, "R1");
    drive(3'd0, 2'b10, 32'h8000_0000, 32'h8000_0000, 1'b0, "R5");
    drive(3'd0, 2'b01, 32'h00FE, 32'h0101, 1'b0, "R7");
    drive(3'd7, 2'b10, 32'hDEAD_BEEF, 32'h1, 1'b1, "R10");

    for (int i = 0; i < 400; i++) begin
      drive(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), $urandom, $urandom,
            1'($urandom_range(0, 1)), "mixed");
    end

    // Back-to-back requests with no gap.
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      op = 3'd0; size = 2'b00; opa = 32'(i); opb = 32'(i * 3); carry_in = 1'b0;
      in_valid = 1'b1;
      forever begin
        #3;
        if (in_ready) break;
        @(negedge clk);
      end
      sbq.push_back(model(3'd0, 2'b00, 32'(i), 32'(i * 3), 1'b0, "R11"));
      @(negedge clk);
    end
    in_valid = 1'b0;

    repeat (40) @(negedge clk);
    check(sbq.size() == 0, "R11", "pending results", 32'(sbq.size()), 32'h0);
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule